// File: doc/BRIEF.md
# Programmable Clock Output Selector

This block is the digital back end of a programmable clock generator. It takes a reference clock level and a PLL/VCO clock level, both sampled on a fast system clock. It divides them by a programmable post-divider and routes divided or undivided clocks to a primary clock output and to a second clock that can appear on a shared multi-function pin. Two complete configuration sets are held in registers. Each set contains the post-divider value, both source selections and both drive-strength codes. Software writes them through a simple write port.

The shared pin takes one of four roles, chosen by a role input. It can be an enable input, a power-down input, a set-select input, or the output for the second clock. A separate control bit decides how a disabled output looks: released (high impedance) or driven low. Tri-state is modelled as a data bit plus a drive-enable bit for each pad. Enabling and disabling a clock is held off while that clock is low, so no shortened high pulse can leave the block. Changes to the divider value and to the routing are applied only at a divider terminal count, so a half period that has already started always runs to its full length.

Top module: `clk_out_sel`

## Requirements
- R1: A write with `wr_en`=1 stores `wr_data` into set 1 (`wr_bank`=0) or set 2 (`wr_bank`=1). The fields are: [4:0] post-divider P, [6:5] primary source, [8:7] secondary source, [10:9] primary drive code, [12:11] secondary drive code. After reset both sets hold P=1, primary source reference, secondary source reference, and standard drive on both outputs.
- R2: For P≥1 a divided clock has a period of 2·P periods of its input. P=0 is bypass: the divided clock has the period of its input.
- R3: Primary source codes are: 0 = PLL clock divided by 2·P, 1 = raw reference, 2 = reference divided by 2·P.
- R4: Secondary source codes are: 0 = reference, 1 = reference/2, 2 = primary clock, 3 = primary clock/2. The secondary clock is driven on the pin (`pin_oe`=1) when the role is 3.
- R5: Pin role codes are: 0 = enable input, 1 = power-down input, 2 = set-select input, 3 = secondary clock output. In roles 0 to 2 the pin is never driven (`pin_oe`=0).
- R6: In role 0, a pin level of 0 disables the clock outputs and a level of 1 restores normal running. The pin reads as 1 while in reset.
- R7: In role 1, a pin level of 0 puts the block to sleep: the divider counters stop and the outputs take their disabled state. A level of 1 resumes running at the programmed frequency.
- R8: In role 2, a pin level of 1 selects configuration set 1 and a level of 0 selects set 2. The switch happens while the block is running.
- R9: A disabled output has its drive enable low when `dis_hiz_i`=1. When `dis_hiz_i`=0 it has its drive enable high and its data low. Both outputs are disabled during reset.
- R10: `drv0_o` and `drv1_o` carry the drive codes of the applied set: 0 = low, 1 = standard, 2 = high.
- R11: Enabling or disabling an output changes state only while its source is low, so every high pulse on an output has the full source high time.
- R12: A new P or source selection takes effect only at a terminal count of the divider. The half period in progress finishes at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all clock levels |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference clock level |
| pll_i | input | 1 | PLL/VCO clock level |
| wr_en | input | 1 | Configuration write strobe |
| wr_bank | input | 1 | Target set: 0 = set 1, 1 = set 2 |
| wr_data | input | 13 | Configuration word (fields in R1) |
| role_i | input | 2 | Multi-function pin role (R5) |
| dis_hiz_i | input | 1 | Disabled state: 1 = release, 0 = drive low |
| pin_i | input | 1 | Level seen on the multi-function pin |
| pin_o | output | 1 | Data driven onto the multi-function pin |
| pin_oe | output | 1 | Drive enable of the multi-function pin |
| clk0_o | output | 1 | Primary clock data |
| clk0_oe | output | 1 | Primary clock drive enable |
| drv0_o | output | 2 | Primary drive-strength code |
| drv1_o | output | 2 | Secondary drive-strength code |

## Verification
A configuration write is captured on the next edge, but it reaches the outputs only at the next reference-divider terminal count, which can be up to P reference periods later. The pin passes through a two-stage synchronizer, and the output gate adds one more register. For these reasons the frequency checks wait several hundred cycles after any change and then measure whole high and low times between edges, instead of sampling at a fixed offset. The checks that depend on cycle timing are made relative to an observed edge. The terminal-count check writes a new P five cycles into a high phase and expects that phase to last the old 4·8 cycles. The drive-enable and drive-code checks follow the combinational or single-register paths and are sampled on the falling edge after the change.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;

    localparam int P_W   = 5;
    localparam int DRV_W = 2;

    typedef enum logic [1:0] {C0_PLL_DIV = 2'd0, C0_REF = 2'd1, C0_REF_DIV = 2'd2} c0_src_e;
    typedef enum logic [1:0] {C1_REF = 2'd0, C1_REF_HALF = 2'd1, C1_CLK0 = 2'd2, C1_CLK0_HALF = 2'd3} c1_src_e;
    typedef enum logic [1:0] {ROLE_OE = 2'd0, ROLE_PDN = 2'd1, ROLE_FSEL = 2'd2, ROLE_CLK1 = 2'd3} pin_role_e;
    typedef enum logic [1:0] {DRV_LOW = 2'd0, DRV_STD = 2'd1, DRV_HIGH = 2'd2} drv_e;

    typedef struct packed {
        drv_e           drv1;
        drv_e           drv0;
        c1_src_e        c1;
        c0_src_e        c0;
        logic [P_W-1:0] p;
    } cfg_set_t;

    localparam int CFG_W = $bits(cfg_set_t);

    localparam cfg_set_t CFG_RST = '{drv1: DRV_STD, drv0: DRV_STD, c1: C1_REF,
                                     c0: C0_REF, p: P_W'(1)};

    function automatic logic c0_pick(c0_src_e s, logic pll_div, logic ref_lvl, logic ref_div);
        case (s)
            C0_PLL_DIV: return pll_div;
            C0_REF_DIV: return ref_div;
            default:    return ref_lvl;
        endcase
    endfunction

    function automatic logic c1_pick(c1_src_e s, logic ref_lvl, logic ref_half,
                                     logic c0, logic c0_half);
        case (s)
            C1_REF:      return ref_lvl;
            C1_REF_HALF: return ref_half;
            C1_CLK0:     return c0;
            default:     return c0_half;
        endcase
    endfunction

endpackage

// File: rtl/clk_post_div.sv
module clk_post_div
    import clk_sel_pkg::*;
#(
    parameter int PW    = P_W,
    parameter int P_INI = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          lvl,
    input  logic [PW-1:0] req_p,
    output logic          div_o,
    output logic          tc_o
);

    logic          lvl_d;
    logic          q;
    logic [PW-1:0] cnt;
    logic [PW-1:0] act_p;
    logic          rise;
    logic          at_end;

    assign rise   = lvl & ~lvl_d;
    assign at_end = (act_p == '0) || (cnt == act_p - PW'(1));
    assign tc_o   = en & rise & at_end;
    assign div_o  = (act_p == '0) ? lvl : q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d <= 1'b0;
            q     <= 1'b0;
            cnt   <= '0;
            act_p <= PW'(P_INI);
        end else if (en) begin
            lvl_d <= lvl;
            if (rise) begin
                if (at_end) begin
                    cnt   <= '0;
                    act_p <= req_p;
                    if (act_p != '0) q <= ~q;
                end else begin
                    cnt <= cnt + PW'(1);
                end
            end
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (act_p != '0) |-> (cnt < act_p));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt) && $stable(q));

    // R12
    p_load_chk: assert property (@(posedge clk) disable iff (rst)
        (act_p != $past(act_p)) |-> (cnt == '0));

endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic en_req,
    input  logic force_off,
    output logic q_o,
    output logic en_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o <= 1'b0;
            q_o  <= 1'b0;
        end else begin
            if (force_off)  en_o <= 1'b0;
            else if (!src)  en_o <= en_req;
            q_o <= en_o & src & ~force_off;
        end
    end

    // R11
    glitch_free_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!force_off) && (en_o != $past(en_o))) |-> !$past(src));

endmodule

// File: rtl/clk_out_sel.sv
module clk_out_sel
    import clk_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_i,
    input  logic             pll_i,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [1:0]       role_i,
    input  logic             dis_hiz_i,
    input  logic             pin_i,
    output logic             pin_o,
    output logic             pin_oe,
    output logic             clk0_o,
    output logic             clk0_oe,
    output logic [DRV_W-1:0] drv0_o,
    output logic [DRV_W-1:0] drv1_o
);

    cfg_set_t  set1, set2, cfg_req;
    c0_src_e   act_c0;
    c1_src_e   act_c1;
    drv_e      act_drv0, act_drv1;
    pin_role_e role;

    logic [SYNC_STAGES-1:0] pin_sync;
    logic pin_s, sleep, oe_req, use_set2, run;
    logic ref_q, pll_q, ref_prev, c0_prev, ref_half, c0_half;
    logic ref_div, pll_div, ref_tc, pll_tc;
    logic c0_src, c1_src, en0, en1, g0_q, g1_q;

    assign role     = pin_role_e'(role_i);
    assign pin_s    = pin_sync[SYNC_STAGES-1];
    assign sleep    = (role == ROLE_PDN)  && !pin_s;
    assign oe_req   = !((role == ROLE_OE) && !pin_s);
    assign use_set2 = (role == ROLE_FSEL) && !pin_s;
    assign run      = !sleep;
    assign cfg_req  = use_set2 ? set2 : set1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_sync <= '1;
            set1     <= CFG_RST;
            set2     <= CFG_RST;
            ref_q    <= 1'b0;
            pll_q    <= 1'b0;
        end else begin
            pin_sync <= {pin_sync[SYNC_STAGES-2:0], pin_i};
            ref_q    <= ref_i;
            pll_q    <= pll_i;
            if (wr_en && !wr_bank) set1 <= cfg_set_t'(wr_data);
            if (wr_en &&  wr_bank) set2 <= cfg_set_t'(wr_data);
        end
    end

    clk_post_div #(.PW(P_W), .P_INI(1)) u_ref_div (
        .clk(clk), .rst(rst), .en(run), .lvl(ref_q),
        .req_p(cfg_req.p), .div_o(ref_div), .tc_o(ref_tc)
    );

    clk_post_div #(.PW(P_W), .P_INI(1)) u_pll_div (
        .clk(clk), .rst(rst), .en(run), .lvl(pll_q),
        .req_p(cfg_req.p), .div_o(pll_div), .tc_o(pll_tc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_c0   <= CFG_RST.c0;
            act_c1   <= CFG_RST.c1;
            act_drv0 <= CFG_RST.drv0;
            act_drv1 <= CFG_RST.drv1;
        end else if (ref_tc) begin
            act_c0   <= cfg_req.c0;
            act_c1   <= cfg_req.c1;
            act_drv0 <= cfg_req.drv0;
            act_drv1 <= cfg_req.drv1;
        end
    end

    assign c0_src = c0_pick(act_c0, pll_div, ref_q, ref_div);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_prev <= 1'b0;
            c0_prev  <= 1'b0;
            ref_half <= 1'b0;
            c0_half  <= 1'b0;
        end else if (run) begin
            ref_prev <= ref_q;
            c0_prev  <= c0_src;
            if (ref_q && !ref_prev) ref_half <= ~ref_half;
            if (c0_src && !c0_prev) c0_half  <= ~c0_half;
        end
    end

    assign c1_src = c1_pick(act_c1, ref_q, ref_half, c0_src, c0_half);

    clk_out_gate u_gate0 (
        .clk(clk), .rst(rst), .src(c0_src), .en_req(oe_req),
        .force_off(sleep), .q_o(g0_q), .en_o(en0)
    );

    clk_out_gate u_gate1 (
        .clk(clk), .rst(rst), .src(c1_src), .en_req(oe_req),
        .force_off(sleep), .q_o(g1_q), .en_o(en1)
    );

    assign clk0_o  = g0_q;
    assign clk0_oe = en0 | ~dis_hiz_i;
    assign pin_o   = g1_q;
    assign pin_oe  = (role == ROLE_CLK1) && (en1 | ~dis_hiz_i);
    assign drv0_o  = act_drv0;
    assign drv1_o  = act_drv1;

    // R12
    src_apply_chk: assert property (@(posedge clk) disable iff (rst)
        ((act_c0 != $past(act_c0)) || (act_c1 != $past(act_c1))) |-> $past(ref_tc));

    // R7
    sleep_stop_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !ref_tc && !pll_tc);

    // R9
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en0 |=> !clk0_o);

endmodule

// File: tb/clk_out_sel_tb.sv
module clk_out_sel_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_i = 1'b0, pll_i = 1'b0;
    logic        wr_en = 1'b0, wr_bank = 1'b0;
    logic [12:0] wr_data = '0;
    logic [1:0]  role_i = 2'd0;
    logic        dis_hiz_i = 1'b1;
    logic        pin_i = 1'b1;
    logic        pin_o, pin_oe, clk0_o, clk0_oe;
    logic [1:0]  drv0_o, drv1_o;

    int n_chk = 0, n_fail = 0;
    bit mon_on = 0;
    int min_hi = 999;

    clk_out_sel u_dut (
        .clk(clk), .rst(rst), .ref_i(ref_i), .pll_i(pll_i),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
        .role_i(role_i), .dis_hiz_i(dis_hiz_i), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .clk0_o(clk0_o), .clk0_oe(clk0_oe),
        .drv0_o(drv0_o), .drv1_o(drv1_o)
    );

    initial forever #4 clk = ~clk;
    // reference: period 8 cycles; PLL: period 6 cycles
    initial forever begin repeat (4) @(negedge clk); ref_i = ~ref_i; end
    initial forever begin repeat (3) @(negedge clk); pll_i = ~pll_i; end

    typedef struct packed {
        logic [4:0] p;
        logic [1:0] c0;
        logic [1:0] c1;
        int         e0;
        int         e1;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{p: 5'd1, c0: 2'd1, c1: 2'd0, e0: 8,  e1: 8},
        '{p: 5'd2, c0: 2'd2, c1: 2'd1, e0: 32, e1: 16},
        '{p: 5'd3, c0: 2'd0, c1: 2'd2, e0: 36, e1: 36},
        '{p: 5'd2, c0: 2'd0, c1: 2'd3, e0: 24, e1: 48},
        '{p: 5'd0, c0: 2'd2, c1: 2'd3, e0: 8,  e1: 16},
        '{p: 5'd0, c0: 2'd0, c1: 2'd2, e0: 6,  e1: 6}
    };

    function automatic logic [12:0] mk(logic [1:0] d1, logic [1:0] d0, logic [1:0] c1,
                                       logic [1:0] c0, logic [4:0] p);
        return {d1, d0, c1, c0, p};
    endfunction

    function automatic logic get(int w);
        return (w == 0) ? clk0_o : pin_o;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic bank, logic [12:0] d);
        @(negedge clk); wr_en = 1'b1; wr_bank = bank; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic measure(int w, output int per, output int hi);
        int n = 0, h = 0, l = 0;
        logic cur;
        per = -1; hi = -1;
        do begin @(negedge clk); cur = get(w); n++; end while (cur && n < 3000);
        do begin @(negedge clk); cur = get(w); n++; end while (!cur && n < 3000);
        while (cur && n < 3000)  begin h++; @(negedge clk); cur = get(w); n++; end
        while (!cur && n < 3000) begin l++; @(negedge clk); cur = get(w); n++; end
        if (n < 3000) begin per = h + l; hi = h; end
    endtask

    task automatic count_high(int cycles, output int highs);
        highs = 0;
        repeat (cycles) begin @(negedge clk); if (clk0_o) highs++; end
    endtask

    // high-pulse width monitor for the glitch test
    initial begin
        int run = 0;
        forever begin
            @(negedge clk);
            if (clk0_o) run++;
            else begin
                if (run > 0 && mon_on && run < min_hi) min_hi = run;
                run = 0;
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int per, hi, highs;
        // reset state
        repeat (5) @(negedge clk);
        chk("R9 clk0_o in reset", clk0_o, 0);
        chk("R9 clk0_oe in reset", clk0_oe, 0);
        chk("R1 default drive code", drv0_o, 1);
        chk("R5 pin_oe in enable role", pin_oe, 0);
        rst = 1'b0;
        repeat (50) @(negedge clk);
        measure(0, per, hi);
        chk("R1 default source reference", per, 8);

        // vector table, pin in clock-output role
        role_i = 2'd3; dis_hiz_i = 1'b0;
        foreach (VECS[i]) begin
            wr(1'b0, mk(2'd1, 2'd1, VECS[i].c1, VECS[i].c0, VECS[i].p));
            repeat (400) @(negedge clk);
            measure(0, per, hi);
            chk($sformatf("R2 R3 vec%0d clk0 period", i), per, VECS[i].e0);
            measure(1, per, hi);
            chk($sformatf("R4 vec%0d clk1 period", i), per, VECS[i].e1);
        end
        chk("R4 pin driven in clock role", pin_oe, 1);

        // enable role
        role_i = 2'd0; pin_i = 1'b1;
        wr(1'b0, mk(2'd1, 2'd1, 2'd0, 2'd2, 5'd2));
        repeat (400) @(negedge clk);
        pin_i = 1'b0;
        repeat (50) @(negedge clk);
        count_high(200, highs);
        chk("R6 clk0 quiet when disabled", highs, 0);
        chk("R9 drive-low disabled oe", clk0_oe, 1);
        dis_hiz_i = 1'b1;
        @(negedge clk);
        chk("R9 released when disabled", clk0_oe, 0);
        pin_i = 1'b1;
        repeat (300) @(negedge clk);
        measure(0, per, hi);
        chk("R6 clk0 resumes", per, 32);

        // glitch-free gating, high time 16
        @(negedge clk); while (clk0_o) @(negedge clk);
        mon_on = 1; min_hi = 999;
        repeat (37) @(negedge clk); pin_i = 1'b0;
        repeat (53) @(negedge clk); pin_i = 1'b1;
        repeat (71) @(negedge clk); pin_i = 1'b0;
        repeat (29) @(negedge clk); pin_i = 1'b1;
        repeat (200) @(negedge clk);
        mon_on = 0;
        chk("R11 shortest high pulse", min_hi, 16);

        // power-down role
        role_i = 2'd1;
        repeat (300) @(negedge clk);
        pin_i = 1'b0;
        repeat (20) @(negedge clk);
        count_high(200, highs);
        chk("R7 outputs stopped in sleep", highs, 0);
        chk("R7 R9 released in sleep", clk0_oe, 0);
        pin_i = 1'b1;
        repeat (300) @(negedge clk);
        measure(0, per, hi);
        chk("R7 resumes after wake", per, 32);

        // set-select role
        role_i = 2'd2;
        wr(1'b1, mk(2'd1, 2'd1, 2'd0, 2'd2, 5'd3));
        wr(1'b0, mk(2'd1, 2'd1, 2'd0, 2'd2, 5'd1));
        repeat (400) @(negedge clk);
        measure(0, per, hi);
        chk("R8 set 1 selected", per, 16);
        chk("R5 pin not driven in select role", pin_oe, 0);
        pin_i = 1'b0;
        repeat (400) @(negedge clk);
        measure(0, per, hi);
        chk("R8 set 2 selected", per, 48);
        pin_i = 1'b1;

        // terminal-count application
        role_i = 2'd0;
        wr(1'b0, mk(2'd1, 2'd1, 2'd0, 2'd2, 5'd4));
        repeat (400) @(negedge clk);
        begin
            int h = 0, l = 0;
            @(negedge clk); while (clk0_o) @(negedge clk);
            while (!clk0_o) @(negedge clk);
            while (clk0_o) begin
                h++;
                if (h == 5) begin wr_en = 1'b1; wr_bank = 1'b0;
                    wr_data = mk(2'd1, 2'd1, 2'd0, 2'd2, 5'd1); end
                if (h == 6) wr_en = 1'b0;
                @(negedge clk);
            end
            wr_en = 1'b0;
            while (!clk0_o) begin l++; @(negedge clk); end
            chk("R12 old half period completes", h, 32);
            chk("R12 new half period after count", l, 8);
        end

        // drive codes
        wr(1'b0, mk(2'd0, 2'd2, 2'd0, 2'd1, 5'd1));
        repeat (100) @(negedge clk);
        chk("R10 primary drive high", drv0_o, 2);
        chk("R10 secondary drive low", drv1_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule